// File: doc/BRIEF.md
# Three-Multiplier Pipelined Complex Multiplier

This block forms the exact product of two signed complex operands while spending only three real multipliers per result. Operand pair (aRe + j·aIm) and (bRe + j·bIm) is split into one shared product and two correction products. The shared product is bRe·(aRe+aIm), and the corrections are aRe·(bIm−bRe) and aIm·(bRe+bIm). The real result is the shared product minus aIm·(bRe+bIm). The imaginary result is the shared product plus aRe·(bIm−bRe).

The pipeline has six register stages: input capture, pre-addition, a two-stage product, post-addition and the output register. It accepts one operand pair on every clock and never stalls. A valid flag travels alongside the data. That flag also enables each data stage, so the outputs keep the last result while no new result is due. Results keep full precision, 2·DATA_W+2 bits wide, and any rounding is left to the consumer.

Top module: `cplx_mul3`

## Requirements
- R1: outRe equals aRe·bRe − aIm·bIm exactly, as a signed two's-complement value of 2·DATA_W+2 bits (34 bits for DATA_W = 16).
- R2: outIm equals aRe·bIm + aIm·bRe exactly, in the same signed 2·DATA_W+2 bit format.
- R3: The result of an operand pair presented with inValid high in one clock cycle appears on the outputs six clock cycles later. It is visible right after the fifth rising edge that follows the edge sampling the operands.
- R4: A new operand pair is accepted on every clock with no gaps needed. Back-to-back pairs yield back-to-back results, each depending only on its own operands.
- R5: outValid is inValid delayed by exactly six clock cycles, so every accepted pair produces exactly one output cycle with outValid high.
- R6: Operands presented while inValid is low are ignored. While outValid is low, outRe and outIm hold the most recent valid result, or zero if none has been produced since reset.
- R7: Results are exact for extreme operands, including the most negative value −2^(DATA_W−1) on any input. For example, (−32768 − j32768)·(−32768 − j32768) gives real 0 and imaginary 2^31.
- R8: An active-low asynchronous reset (rstN low) forces outValid, outRe and outIm to zero. It discards every operand pair still in flight, so no outValid pulse follows reset release until new operands arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all registers on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Marks the operand pair on aRe/aIm/bRe/bIm as valid this cycle |
| aRe | input | DATA_W | Real part of the first operand, signed |
| aIm | input | DATA_W | Imaginary part of the first operand, signed |
| bRe | input | DATA_W | Real part of the second operand, signed |
| bIm | input | DATA_W | Imaginary part of the second operand, signed |
| outValid | output | 1 | High in the cycle a result is presented |
| outRe | output | 2·DATA_W+2 | Real part of the product, signed, full precision |
| outIm | output | 2·DATA_W+2 | Imaginary part of the product, signed, full precision |

## Verification
The bench targets the extreme operand values first: every combination of the most negative, most positive, zero and minus one is applied, and a narrow instance is swept over all of its operand combinations. A pre-adder without its extra bit would wrap there and flip the sign of a product. A mis-ordered correction term would give the swapped or negated part of the result.

The bench also checks latency and hold behaviour under streams where valid pairs alternate with garbage-filled idle cycles. An off-by-one stage would shift outValid against the data. An ungated register would let idle garbage reach the held outputs.

Finally, a reset is applied while operand pairs are still in flight. The bench checks that no stale pulse emerges after reset release.

// File: rtl/cmul3_pkg.sv
package cmul3_pkg;

  // Register stages between the operand ports and the result ports.
  localparam int PIPE_DEPTH = 6;

  // Real multiplications used per complex product.
  localparam int NUM_MUL = 3;

  // Per-stage load strobes issued by the control to the datapath.
  typedef struct packed {
    logic ldIn;    // capture operands
    logic ldPre;   // pre-adder stage
    logic ldMulA;  // first product register
    logic ldMulB;  // second product register
    logic ldPost;  // post-adder stage
    logic ldOut;   // output register
  } cmul3_strobe_t;

endpackage

// File: rtl/cmul3_ctrl.sv
module cmul3_ctrl
  import cmul3_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output cmul3_strobe_t strb,
  output logic          outValid
);

  // Valid token shift register: bit k set means stage k+1 holds live data.
  logic [PIPE_DEPTH-1:0] vPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vPipe <= '0;
    end else begin
      vPipe <= {vPipe[PIPE_DEPTH-2:0], inValid};
    end
  end

  // Each data stage loads exactly when the token reaches it.
  assign strb.ldIn   = inValid;
  assign strb.ldPre  = vPipe[0];
  assign strb.ldMulA = vPipe[1];
  assign strb.ldMulB = vPipe[2];
  assign strb.ldPost = vPipe[3];
  assign strb.ldOut  = vPipe[4];
  assign outValid    = vPipe[PIPE_DEPTH-1];

  // Cycles since reset release, saturating; only lets the checker know
  // how much reset-free history exists.
  logic [2:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
    end else if (sinceRst != 3'd7) begin
      sinceRst <= sinceRst + 3'd1;
    end
  end

  // R5
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd6) |-> (outValid == $past(inValid, 6)));

endmodule

// File: rtl/cmul3_prod.sv
module cmul3_prod #(
  parameter int X_W = 17,
  parameter int Y_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        ldA,
  input  logic                        ldB,
  input  logic signed [X_W-1:0]       xIn,
  input  logic signed [Y_W-1:0]       yIn,
  output logic signed [X_W+Y_W-1:0]   pOut
);

  localparam int P_W = X_W + Y_W;

  logic signed [P_W-1:0] stageA;
  logic signed [P_W-1:0] stageB;

  // Two register levels so the multiplier can be balanced across them.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageA <= '0;
      stageB <= '0;
    end else begin
      if (ldA) stageA <= P_W'(xIn) * P_W'(yIn);
      if (ldB) stageB <= stageA;
    end
  end

  assign pOut = stageB;

endmodule

// File: rtl/cmul3_dp.sv
module cmul3_dp
  import cmul3_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  cmul3_strobe_t                strb,
  input  logic signed [DATA_W-1:0]     aIn,
  input  logic signed [DATA_W-1:0]     bIn,
  input  logic signed [DATA_W-1:0]     cIn,
  input  logic signed [DATA_W-1:0]     dIn,
  output logic signed [2*DATA_W+1:0]   outRe,
  output logic signed [2*DATA_W+1:0]   outIm
);

  localparam int PRE_W  = DATA_W + 1;     // pre-adder result, one guard bit
  localparam int PROD_W = PRE_W + DATA_W; // product of pre-sum and operand
  localparam int OUT_W  = PROD_W + 1;     // post-adder result

  // Stage 1: operand capture
  logic signed [DATA_W-1:0] aS1, bS1, cS1, dS1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aS1 <= '0;
      bS1 <= '0;
      cS1 <= '0;
      dS1 <= '0;
    end else if (strb.ldIn) begin
      aS1 <= aIn;
      bS1 <= bIn;
      cS1 <= cIn;
      dS1 <= dIn;
    end
  end

  // Stage 2: pre-adders, widened by one bit so extreme inputs cannot wrap
  logic signed [PRE_W-1:0]  preAB, preDC, preCD;
  logic signed [DATA_W-1:0] aS2, bS2, cS2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preAB <= '0;
      preDC <= '0;
      preCD <= '0;
      aS2   <= '0;
      bS2   <= '0;
      cS2   <= '0;
    end else if (strb.ldPre) begin
      preAB <= PRE_W'(aS1) + PRE_W'(bS1);
      preDC <= PRE_W'(dS1) - PRE_W'(cS1);
      preCD <= PRE_W'(cS1) + PRE_W'(dS1);
      aS2   <= aS1;
      bS2   <= bS1;
      cS2   <= cS1;
    end
  end

  // Stages 3-4: three real products
  //   [0] shared  : c*(a+b)
  //   [1] imag fix: a*(d-c)
  //   [2] real fix: b*(c+d)
  logic signed [PRE_W-1:0]  mulX [NUM_MUL];
  logic signed [DATA_W-1:0] mulY [NUM_MUL];
  logic signed [PROD_W-1:0] prod [NUM_MUL];

  assign mulX[0] = preAB;
  assign mulY[0] = cS2;
  assign mulX[1] = preDC;
  assign mulY[1] = aS2;
  assign mulX[2] = preCD;
  assign mulY[2] = bS2;

  for (genvar gi = 0; gi < NUM_MUL; gi++) begin : g_mul
    cmul3_prod #(
      .X_W (PRE_W),
      .Y_W (DATA_W)
    ) u_prod (
      .clk  (clk),
      .rstN (rstN),
      .ldA  (strb.ldMulA),
      .ldB  (strb.ldMulB),
      .xIn  (mulX[gi]),
      .yIn  (mulY[gi]),
      .pOut (prod[gi])
    );
  end

  // Stage 5: post-adders
  logic signed [OUT_W-1:0] postRe, postIm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      postRe <= '0;
      postIm <= '0;
    end else if (strb.ldPost) begin
      postRe <= OUT_W'(prod[0]) - OUT_W'(prod[2]);
      postIm <= OUT_W'(prod[0]) + OUT_W'(prod[1]);
    end
  end

  // Stage 6: output register, holds between results
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outRe <= '0;
      outIm <= '0;
    end else if (strb.ldOut) begin
      outRe <= postRe;
      outIm <= postIm;
    end
  end

  // R1
  real_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.ldOut) |->
      (outRe == $past(OUT_W'(aIn) * OUT_W'(cIn) - OUT_W'(bIn) * OUT_W'(dIn), 6)));

  // R2
  imag_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.ldOut) |->
      (outIm == $past(OUT_W'(aIn) * OUT_W'(dIn) + OUT_W'(bIn) * OUT_W'(cIn), 6)));

  // R6
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.ldOut) |-> ($stable(outRe) && $stable(outIm)));

endmodule

// File: rtl/cplx_mul3.sv
module cplx_mul3
  import cmul3_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic signed [DATA_W-1:0]    aRe,
  input  logic signed [DATA_W-1:0]    aIm,
  input  logic signed [DATA_W-1:0]    bRe,
  input  logic signed [DATA_W-1:0]    bIm,
  output logic                        outValid,
  output logic signed [2*DATA_W+1:0]  outRe,
  output logic signed [2*DATA_W+1:0]  outIm
);

  cmul3_strobe_t strb;

  cmul3_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strb     (strb),
    .outValid (outValid)
  );

  // a = aRe, b = aIm, c = bRe, d = bIm
  cmul3_dp #(
    .DATA_W (DATA_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .aIn   (aRe),
    .bIn   (aIm),
    .cIn   (bRe),
    .dIn   (bIm),
    .outRe (outRe),
    .outIm (outIm)
  );

endmodule

// File: tb/cplx_mul3_bench.sv
module cplx_mul3_bench;

  localparam int W   = 16;
  localparam int WS  = 4;
  localparam int OW  = 2 * W + 2;
  localparam int OWS = 2 * WS + 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic rstN;

  // full-width instance
  logic                 v16;
  logic signed [W-1:0]  a16, b16, c16, d16;
  logic                 o16v;
  logic signed [OW-1:0] re16, im16;

  // narrow instance for the exhaustive sweep
  logic                  v4;
  logic signed [WS-1:0]  a4, b4, c4, d4;
  logic                  o4v;
  logic signed [OWS-1:0] re4, im4;

  cplx_mul3 #(.DATA_W(W)) u_cplx_mul3 (
    .clk(clk), .rstN(rstN), .inValid(v16),
    .aRe(a16), .aIm(b16), .bRe(c16), .bIm(d16),
    .outValid(o16v), .outRe(re16), .outIm(im16)
  );

  cplx_mul3 #(.DATA_W(WS)) u_cplx_mul3_w4 (
    .clk(clk), .rstN(rstN), .inValid(v4),
    .aRe(a4), .aIm(b4), .bRe(c4), .bIm(d4),
    .outValid(o4v), .outRe(re4), .outIm(im4)
  );

  int nTests = 0;
  int nFail  = 0;

  // Expected-value history per instance: entry 5 was driven six cycles ago.
  bit     histV   [2][6];
  longint histRe  [2][6];
  longint histIm  [2][6];
  string  histTag [2][6];
  longint lastRe  [2];
  longint lastIm  [2];

  task automatic checkVal(string tag, string what, longint act, longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic clearHist();
    for (int i = 0; i < 2; i++) begin
      for (int k = 0; k < 6; k++) begin
        histV[i][k]   = 1'b0;
        histRe[i][k]  = 0;
        histIm[i][k]  = 0;
        histTag[i][k] = "";
      end
      lastRe[i] = 0;
      lastIm[i] = 0;
    end
  endtask

  function automatic longint rnd16();
    return longint'($signed(16'($urandom)));
  endfunction

  // One clock cycle for one instance: check its outputs, then drive new inputs.
  task automatic step(int inst, bit v, longint a, longint b, longint c, longint d, string tag);
    bit     actV;
    longint actRe;
    longint actIm;
    string  tRe;
    string  tIm;
    @(negedge clk);
    if (inst == 0) begin
      actV = o16v; actRe = re16; actIm = im16;
    end else begin
      actV = o4v;  actRe = re4;  actIm = im4;
    end
    if (histV[inst][5]) begin
      tRe = (histTag[inst][5] == "") ? "R1" : histTag[inst][5];
      tIm = (histTag[inst][5] == "") ? "R2" : histTag[inst][5];
      checkVal("R3", "outValid after six cycles", longint'(actV), 1);
      checkVal(tRe, "real part", actRe, histRe[inst][5]);
      checkVal(tIm, "imag part", actIm, histIm[inst][5]);
      lastRe[inst] = histRe[inst][5];
      lastIm[inst] = histIm[inst][5];
    end else begin
      checkVal("R5", "outValid idle", longint'(actV), 0);
      checkVal("R6", "held real part", actRe, lastRe[inst]);
      checkVal("R6", "held imag part", actIm, lastIm[inst]);
    end
    for (int k = 5; k > 0; k--) begin
      histV[inst][k]   = histV[inst][k-1];
      histRe[inst][k]  = histRe[inst][k-1];
      histIm[inst][k]  = histIm[inst][k-1];
      histTag[inst][k] = histTag[inst][k-1];
    end
    histV[inst][0]   = v;
    histRe[inst][0]  = a * c - b * d;
    histIm[inst][0]  = a * d + b * c;
    histTag[inst][0] = tag;
    if (inst == 0) begin
      v16 = v; a16 = a[W-1:0]; b16 = b[W-1:0]; c16 = c[W-1:0]; d16 = d[W-1:0];
    end else begin
      v4 = v;  a4 = a[WS-1:0]; b4 = b[WS-1:0]; c4 = c[WS-1:0]; d4 = d[WS-1:0];
    end
  endtask

  // Idle cycles with garbage on the operand inputs (R6: must be ignored).
  task automatic idle(int inst, int n);
    for (int i = 0; i < n; i++) step(inst, 1'b0, rnd16(), rnd16(), rnd16(), rnd16(), "");
  endtask

  task automatic checkResetOutputs();
    checkVal("R8", "outValid in reset", longint'(o16v), 0);
    checkVal("R8", "outRe in reset", longint'(re16), 0);
    checkVal("R8", "outIm in reset", longint'(im16), 0);
    checkVal("R8", "narrow outValid in reset", longint'(o4v), 0);
    checkVal("R8", "narrow outRe in reset", longint'(re4), 0);
    checkVal("R8", "narrow outIm in reset", longint'(im4), 0);
  endtask

  task automatic runAll();
    longint cv [4];
    cv[0] = -32768; cv[1] = 32767; cv[2] = 0; cv[3] = -1;

    // reset state (R8)
    rstN = 1'b0;
    v16 = 1'b0; a16 = '0; b16 = '0; c16 = '0; d16 = '0;
    v4  = 1'b0; a4  = '0; b4  = '0; c4  = '0; d4  = '0;
    clearHist();
    repeat (3) @(negedge clk);
    checkResetOutputs();
    rstN = 1'b1;

    // isolated pair: (3+4j)(5+6j) = -9+38j, latency and valid pulse (R3, R5)
    step(0, 1'b1, 3, 4, 5, 6, "");
    idle(0, 8);

    // extreme operand combinations, back to back (R7, R4)
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int k = 0; k < 4; k++)
          for (int m = 0; m < 4; m++)
            step(0, 1'b1, cv[i], cv[j], cv[k], cv[m], "R7");
    // the squared most-negative pair: real 0, imag 2^31 (R7)
    step(0, 1'b1, -32768, -32768, -32768, -32768, "R7");
    idle(0, 8);

    // random stream with garbage-filled idle cycles (R4, R6)
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 4) != 0) step(0, 1'b1, rnd16(), rnd16(), rnd16(), rnd16(), "");
      else                     step(0, 1'b0, rnd16(), rnd16(), rnd16(), rnd16(), "");
    end
    idle(0, 8);

    // reset with pairs in flight (R8)
    step(0, 1'b1, 100, 200, -300, 400, "");
    step(0, 1'b1, -7, 9, 11, -13, "");
    step(0, 1'b1, 32767, -32768, 1, 2, "");
    @(negedge clk);
    rstN = 1'b0;
    v16 = 1'b0;
    #1;
    checkResetOutputs();
    repeat (2) @(negedge clk);
    clearHist();
    rstN = 1'b1;
    idle(0, 8);   // no stale pulse after release, outputs stay zero (R8)

    // exhaustive sweep of the narrow instance (R1, R2, R4, R7)
    for (int a = -8; a < 8; a++)
      for (int b = -8; b < 8; b++)
        for (int c = -8; c < 8; c++)
          for (int d = -8; d < 8; d++)
            step(1, 1'b1, a, b, c, d, "");
    for (int i = 0; i < 8; i++) step(1, 1'b0, 5, -3, 7, -8, "");
  endtask

  initial begin
    runAll();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule